// File: doc/BRIEF.md
# System Segment Register Loader

This block holds the two descriptor-table pointers that software writes directly: one for the global table and one for the interrupt table. Each has a 32-bit base and a 16-bit byte limit. Its main job is to load the local-table register and the task register from a 16-bit selector. A load first checks the selector. It then reads the 8-byte descriptor from the global table through a simple read port that takes two 32-bit reads. It checks the descriptor's type and, if all is well, fills a hidden cache with the selector, base, limit and attributes. The rest of the processor uses that cache for later accesses.

A load starts with a one-cycle request that names the target register and carries the selector. It ends with a one-cycle done pulse that carries a fault code. Several problems stop a load before any memory read: a null selector aimed at the task register, a selector that points at a local table, and a descriptor that would run past the global table limit. A null selector aimed at the local-table register is legal. It marks the task as having no local table and needs no read. The cache of the targeted register is left untouched whenever a load faults.

Top module: `sysreg_loader`

## Requirements
- R1: After reset, every table pointer, both caches (selector, base, limit, attributes, valid flag), `ld_busy`, `ld_done`, `ld_fault` and `mem_rd_req` are zero.
- R2: A write with `tbl_wr_en` stores `tbl_wr_data[47:16]` as base and `tbl_wr_data[15:0]` as limit, into the global pointer when `tbl_wr_sel`=0 and into the interrupt pointer when `tbl_wr_sel`=1. The new value is visible from the next cycle. An interrupt-table limit above 0x7FF (256 vectors × 8 − 1) is stored as 0x7FF.
- R3: A selector with bits [15:2] all zero is null. A null load to the local-table register (`ld_target`=0) does no memory read. It ends with fault code 0 and leaves that cache holding the selector, base 0, limit 0, attributes 0 and valid 0.
- R4: A null load to the task register (`ld_target`=1) ends with fault code 1, does no read, and leaves the task cache unchanged.
- R5: A non-null selector with bit 2 set ends with fault code 2, does no read, and leaves the cache unchanged.
- R6: If index×8+7 is greater than the global limit, where the index is selector bits [15:3], the load ends with fault code 3, does no read, and leaves the cache unchanged.
- R7: A load that passes R3 to R6 reads exactly two words: the low dword at global base + index×8, then the high dword at that address + 4. `mem_rd_req` and `mem_rd_addr` are held until `mem_rd_valid` arrives.
- R8: Bits [12:8] of the high dword form the type code. Accepted codes are 0x02 for the local-table register, and 0x09 or 0x01 for the task register. Any other code ends the load with fault code 4 and leaves the cache unchanged.
- R9: On success the cache holds the selector, valid 1, and the following fields, with lo and hi being the low and high dwords:
  - base = {hi[31:24], hi[7:0], lo[31:16]}
  - limit = {hi[19:16], lo[15:0]}
  - attributes = {hi[23:20], hi[15:8]}

  The load ends with fault code 0.
- R10: `ld_done` is a one-cycle pulse. It comes one cycle after acceptance when the load needs no read. `ld_fault` is zero outside that pulse. `ld_req` is ignored while `ld_busy` is high.
- R11: A global-pointer write in the same cycle as an accepted `ld_req` takes effect after that edge. The load's limit check and read address use the previous pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Table pointer write strobe |
| tbl_wr_sel | input | 1 | 0 = global pointer, 1 = interrupt pointer |
| tbl_wr_data | input | 48 | {base[31:0], limit[15:0]} |
| ld_req | input | 1 | Start a selector load |
| ld_target | input | 1 | 0 = local-table register, 1 = task register |
| ld_sel | input | 16 | Selector to load |
| mem_rd_req | output | 1 | Read request, held until valid |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| gdt_base | output | 32 | Global table base |
| gdt_limit | output | 16 | Global table limit |
| idt_base | output | 32 | Interrupt table base |
| idt_limit | output | 16 | Interrupt table limit |
| ldt_sel | output | 16 | Local-table cache selector |
| ldt_base | output | 32 | Local-table cache base |
| ldt_limit | output | 20 | Local-table cache limit |
| ldt_attr | output | 12 | Local-table cache attributes |
| ldt_valid | output | 1 | Local table present |
| tr_sel | output | 16 | Task cache selector |
| tr_base | output | 32 | Task cache base |
| tr_limit | output | 20 | Task cache limit |
| tr_attr | output | 12 | Task cache attributes |
| tr_valid | output | 1 | Task cache loaded |
| ld_busy | output | 1 | Load in progress |
| ld_done | output | 1 | Load finished (one cycle) |
| ld_fault | output | 3 | Fault code, valid with `ld_done` |

## Verification
A software write to the global pointer can land in the same cycle in which a load is accepted. The load's limit check and its read address must then use the old pointer, while later loads use the new one. The bench provokes this by driving both strobes on the same clock edge, once with a moved base and once with a widened limit that would admit a selector the old limit rejects. It judges the result by the read addresses it logs and by the fault code, and then confirms that a following load reads from the new base.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int SEL_W  = 16;
  localparam int IDX_W  = 13;
  localparam int BASE_W = 32;
  localparam int TLIM_W = 16;
  localparam int DLIM_W = 20;
  localparam int ATTR_W = 12;
  localparam int WORD_W = 32;
  localparam int TYP_W  = 5;

  localparam logic TGT_LDT = 1'b0;
  localparam logic TGT_TR  = 1'b1;

  localparam logic [TYP_W-1:0] TYP_LDT   = 5'h02;
  localparam logic [TYP_W-1:0] TYP_TSS32 = 5'h09;
  localparam logic [TYP_W-1:0] TYP_TSS16 = 5'h01;

  typedef enum logic [2:0] {
    F_NONE  = 3'd0,
    F_NULL  = 3'd1,
    F_TI    = 3'd2,
    F_LIMIT = 3'd3,
    F_TYPE  = 3'd4
  } ld_fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_FIN
  } ld_state_e;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [BASE_W-1:0] base;
    logic [DLIM_W-1:0] limit;
    logic [ATTR_W-1:0] attr;
    logic              valid;
  } seg_cache_t;

  function automatic seg_cache_t unpack_desc(input logic [WORD_W-1:0] lo,
                                             input logic [WORD_W-1:0] hi,
                                             input logic [SEL_W-1:0]  sel);
    seg_cache_t c;
    c.sel   = sel;
    c.base  = {hi[31:24], hi[7:0], lo[31:16]};
    c.limit = {hi[19:16], lo[15:0]};
    c.attr  = {hi[23:20], hi[15:8]};
    c.valid = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/sysreg_tbl_regs.sv
module sysreg_tbl_regs
  import sysreg_pkg::*;
#(
  parameter int IDT_VECTORS = 256
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [BASE_W+TLIM_W-1:0] wr_data,
  output logic [BASE_W-1:0]    gdt_base,
  output logic [TLIM_W-1:0]    gdt_limit,
  output logic [BASE_W-1:0]    idt_base,
  output logic [TLIM_W-1:0]    idt_limit
);
  localparam logic [TLIM_W-1:0] IDT_LIM_MAX = TLIM_W'(IDT_VECTORS * 8 - 1);

  logic [BASE_W-1:0] gbase_q, gbase_d, ibase_q, ibase_d;
  logic [TLIM_W-1:0] glim_q, glim_d, ilim_q, ilim_d;
  logic [TLIM_W-1:0] wr_lim;

  assign wr_lim = wr_data[TLIM_W-1:0];

  always_comb begin
    gbase_d = gbase_q;
    glim_d  = glim_q;
    ibase_d = ibase_q;
    ilim_d  = ilim_q;
    if (wr_en && !wr_sel) begin
      gbase_d = wr_data[BASE_W+TLIM_W-1:TLIM_W];
      glim_d  = wr_lim;
    end
    if (wr_en && wr_sel) begin
      ibase_d = wr_data[BASE_W+TLIM_W-1:TLIM_W];
      ilim_d  = (wr_lim > IDT_LIM_MAX) ? IDT_LIM_MAX : wr_lim;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      gbase_q <= '0;
      glim_q  <= '0;
      ibase_q <= '0;
      ilim_q  <= '0;
    end else begin
      gbase_q <= gbase_d;
      glim_q  <= glim_d;
      ibase_q <= ibase_d;
      ilim_q  <= ilim_d;
    end
  end

  assign gdt_base  = gbase_q;
  assign gdt_limit = glim_q;
  assign idt_base  = ibase_q;
  assign idt_limit = ilim_q;

  // R2
  idt_lim_cap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_sel) |=> (idt_limit <= IDT_LIM_MAX));
endmodule

// File: rtl/sysreg_selchk.sv
module sysreg_selchk
  import sysreg_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic              target,
  input  logic [BASE_W-1:0] gdt_base,
  input  logic [TLIM_W-1:0] gdt_limit,
  output ld_fault_e         fault,
  output logic              is_null,
  output logic [BASE_W-1:0] desc_addr
);
  logic [IDX_W-1:0]  idx;
  logic              ti;
  logic [TLIM_W-1:0] last_byte;

  assign idx       = sel[SEL_W-1:3];
  assign ti        = sel[2];
  assign is_null   = (idx == '0) && !ti;
  assign last_byte = {idx, 3'b111};
  assign desc_addr = gdt_base + BASE_W'({idx, 3'b000});

  always_comb begin
    fault = F_NONE;
    if (is_null) begin
      if (target == TGT_TR) fault = F_NULL;
    end else if (ti) begin
      fault = F_TI;
    end else if (last_byte > gdt_limit) begin
      fault = F_LIMIT;
    end
  end
endmodule

// File: rtl/sysreg_seq.sv
module sysreg_seq
  import sysreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              ld_req,
  input  logic              ld_target,
  input  logic [SEL_W-1:0]  ld_sel,
  input  ld_fault_e         chk_fault,
  input  logic              chk_null,
  input  logic [BASE_W-1:0] chk_addr,
  output logic              mem_rd_req,
  output logic [BASE_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              commit_en,
  output logic              commit_tgt,
  output seg_cache_t        commit_data,
  output logic              ld_busy,
  output logic              ld_done,
  output logic [2:0]        ld_fault
);
  ld_state_e         state_q, state_d;
  logic              tgt_q, tgt_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [BASE_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] lo_q, lo_d;
  ld_fault_e         fault_q, fault_d;
  logic [TYP_W-1:0]  typ;
  logic              typ_ok;

  assign typ    = mem_rd_data[12:8];
  assign typ_ok = (tgt_q == TGT_LDT) ? (typ == TYP_LDT)
                                     : ((typ == TYP_TSS32) || (typ == TYP_TSS16));

  always_comb begin
    state_d     = state_q;
    tgt_d       = tgt_q;
    sel_d       = sel_q;
    addr_d      = addr_q;
    lo_d        = lo_q;
    fault_d     = fault_q;
    commit_en   = 1'b0;
    commit_tgt  = tgt_q;
    commit_data = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (ld_req) begin
          tgt_d   = ld_target;
          sel_d   = ld_sel;
          addr_d  = chk_addr;
          fault_d = chk_fault;
          if (chk_fault != F_NONE) begin
            state_d = ST_FIN;
          end else if (chk_null) begin
            commit_en       = 1'b1;
            commit_tgt      = ld_target;
            commit_data.sel = ld_sel;
            state_d         = ST_FIN;
          end else begin
            state_d = ST_RD_LO;
          end
        end
      end
      ST_RD_LO: begin
        if (mem_rd_valid) begin
          lo_d    = mem_rd_data;
          addr_d  = addr_q + BASE_W'(4);
          state_d = ST_RD_HI;
        end
      end
      ST_RD_HI: begin
        if (mem_rd_valid) begin
          commit_en   = typ_ok;
          commit_data = unpack_desc(lo_q, mem_rd_data, sel_q);
          fault_d     = typ_ok ? F_NONE : F_TYPE;
          state_d     = ST_FIN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tgt_q   <= 1'b0;
      sel_q   <= '0;
      addr_q  <= '0;
      lo_q    <= '0;
      fault_q <= F_NONE;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      sel_q   <= sel_d;
      addr_q  <= addr_d;
      lo_q    <= lo_d;
      fault_q <= fault_d;
    end
  end

  assign mem_rd_req  = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign mem_rd_addr = mem_rd_req ? addr_q : '0;
  assign ld_busy     = (state_q != ST_IDLE);
  assign ld_done     = (state_q == ST_FIN);
  assign ld_fault    = ld_done ? fault_q : F_NONE;

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ld_done |=> !ld_done);
  // R6
  early_fault_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ld_busy && ld_req && (chk_fault != F_NONE)) |=> (ld_done && !mem_rd_req));
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_rd_req && ld_req && !mem_rd_valid) |=> $stable(mem_rd_addr));
endmodule

// File: rtl/sysreg_cache.sv
module sysreg_cache
  import sysreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       commit,
  input  seg_cache_t wr,
  output seg_cache_t rd
);
  seg_cache_t q, d;

  always_comb begin
    d = q;
    if (commit) d = wr;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign rd = q;

  // R8
  cache_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !commit |=> $stable(rd));
endmodule

// File: rtl/sysreg_loader.sv
module sysreg_loader
  import sysreg_pkg::*;
#(
  parameter int IDT_VECTORS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tbl_wr_en,
  input  logic        tbl_wr_sel,
  input  logic [47:0] tbl_wr_data,
  input  logic        ld_req,
  input  logic        ld_target,
  input  logic [15:0] ld_sel,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic [31:0] gdt_base,
  output logic [15:0] gdt_limit,
  output logic [31:0] idt_base,
  output logic [15:0] idt_limit,
  output logic [15:0] ldt_sel,
  output logic [31:0] ldt_base,
  output logic [19:0] ldt_limit,
  output logic [11:0] ldt_attr,
  output logic        ldt_valid,
  output logic [15:0] tr_sel,
  output logic [31:0] tr_base,
  output logic [19:0] tr_limit,
  output logic [11:0] tr_attr,
  output logic        tr_valid,
  output logic        ld_busy,
  output logic        ld_done,
  output logic [2:0]  ld_fault
);
  localparam int N_CACHE = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  ld_fault_e         chk_fault;
  logic              chk_null;
  logic [BASE_W-1:0] chk_addr;
  logic              commit_en, commit_tgt;
  seg_cache_t        commit_data;
  seg_cache_t        cache_rd [N_CACHE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  sysreg_tbl_regs #(.IDT_VECTORS(IDT_VECTORS)) u_tbl (
    .clk(clk), .rst_ni(rst_ni),
    .wr_en(tbl_wr_en), .wr_sel(tbl_wr_sel), .wr_data(tbl_wr_data),
    .gdt_base(gdt_base), .gdt_limit(gdt_limit),
    .idt_base(idt_base), .idt_limit(idt_limit)
  );

  sysreg_selchk u_chk (
    .sel(ld_sel), .target(ld_target),
    .gdt_base(gdt_base), .gdt_limit(gdt_limit),
    .fault(chk_fault), .is_null(chk_null), .desc_addr(chk_addr)
  );

  sysreg_seq u_seq (
    .clk(clk), .rst_ni(rst_ni),
    .ld_req(ld_req), .ld_target(ld_target), .ld_sel(ld_sel),
    .chk_fault(chk_fault), .chk_null(chk_null), .chk_addr(chk_addr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .commit_en(commit_en), .commit_tgt(commit_tgt), .commit_data(commit_data),
    .ld_busy(ld_busy), .ld_done(ld_done), .ld_fault(ld_fault)
  );

  for (genvar g = 0; g < N_CACHE; g++) begin : g_cache
    sysreg_cache u_cache (
      .clk(clk), .rst_ni(rst_ni),
      .commit(commit_en && (commit_tgt == 1'(g))),
      .wr(commit_data),
      .rd(cache_rd[g])
    );
  end

  assign ldt_sel   = cache_rd[0].sel;
  assign ldt_base  = cache_rd[0].base;
  assign ldt_limit = cache_rd[0].limit;
  assign ldt_attr  = cache_rd[0].attr;
  assign ldt_valid = cache_rd[0].valid;
  assign tr_sel    = cache_rd[1].sel;
  assign tr_base   = cache_rd[1].base;
  assign tr_limit  = cache_rd[1].limit;
  assign tr_attr   = cache_rd[1].attr;
  assign tr_valid  = cache_rd[1].valid;

  // R4
  tr_null_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ld_done && tr_valid && !$past(tr_valid)) |-> (tr_sel[15:2] != '0));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ld_done |-> !mem_rd_req);
endmodule

// File: tb/sysreg_loader_tb.sv
module sysreg_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_wr_en, tbl_wr_sel;
  logic [47:0] tbl_wr_data;
  logic        ld_req, ld_target;
  logic [15:0] ld_sel;
  logic        mem_rd_req, mem_rd_valid;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic [31:0] gdt_base, idt_base, ldt_base, tr_base;
  logic [15:0] gdt_limit, idt_limit, ldt_sel, tr_sel;
  logic [19:0] ldt_limit, tr_limit;
  logic [11:0] ldt_attr, tr_attr;
  logic        ldt_valid, tr_valid, ld_busy, ld_done;
  logic [2:0]  ld_fault;

  int checks = 0;
  int failures = 0;
  int lat = 0;
  int wait_cnt = 0;
  int rd_cnt = 0;
  logic [31:0] rd_log [4];

  always #10 clk = ~clk;

  sysreg_loader u_dut (.*);

  function automatic logic [63:0] desc_of(input logic [12:0] idx);
    logic [31:0] base;
    logic [19:0] lim;
    logic [4:0]  typ;
    logic [31:0] lo, hi;
    base = 32'h1000_0000 + 32'(idx) * 32'h0103_0507;
    lim  = 20'h0_0FFF ^ {7'b0, idx};
    case (idx % 5)
      0: typ = 5'h02;
      1: typ = 5'h09;
      2: typ = 5'h01;
      3: typ = 5'h1A;
      default: typ = 5'h0B;
    endcase
    lo = {base[15:0], lim[15:0]};
    hi = {base[31:24], idx[3:0], lim[19:16], 1'b1, idx[1:0], typ, base[23:16]};
    return {hi, lo};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [63:0] d;
    d = desc_of(a[15:3]);
    return a[2] ? d[63:32] : d[31:0];
  endfunction

  assign mem_rd_data = mem_word(mem_rd_addr);

  always @(negedge clk) begin
    if (mem_rd_req) begin
      if (wait_cnt >= lat) begin
        mem_rd_valid <= 1'b1;
        wait_cnt = 0;
        if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
        rd_cnt = rd_cnt + 1;
      end else begin
        mem_rd_valid <= 1'b0;
        wait_cnt = wait_cnt + 1;
      end
    end else begin
      mem_rd_valid <= 1'b0;
      wait_cnt = 0;
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [80:0] exp_c [2];

  function automatic logic [80:0] cache_of(input logic [31:0] lo, input logic [31:0] hi,
                                           input logic [15:0] sel);
    return {sel, hi[31:24], hi[7:0], lo[31:16], hi[19:16], lo[15:0], hi[23:20], hi[15:8], 1'b1};
  endfunction

  task automatic gdt_write(input logic [31:0] b, input logic [15:0] l);
    tbl_wr_en = 1'b1; tbl_wr_sel = 1'b0; tbl_wr_data = {b, l};
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  // Runs a load and compares fault code, reads and both caches with the model.
  task automatic do_load(input logic tgt, input logic [15:0] sel, input logic [31:0] gb,
                         input logic [15:0] gl, input bit poke, input string tag);
    logic [12:0] idx;
    logic [2:0]  ef;
    int          er;
    logic [31:0] ea, lo, hi;
    logic [4:0]  typ;
    bit          ok;
    idx = sel[15:3];
    rd_cnt = 0;
    er = 0;
    ea = gb + {16'b0, idx, 3'b000};
    if (idx == 0 && !sel[2]) begin
      if (tgt) ef = 3'd1;
      else begin ef = 3'd0; exp_c[0] = {sel, 65'b0}; end
    end else if (sel[2]) ef = 3'd2;
    else if ({idx, 3'b111} > gl) ef = 3'd3;
    else begin
      er = 2;
      lo = mem_word(ea);
      hi = mem_word(ea + 4);
      typ = hi[12:8];
      ok = tgt ? (typ == 5'h09 || typ == 5'h01) : (typ == 5'h02);
      if (ok) begin ef = 3'd0; exp_c[tgt] = cache_of(lo, hi, sel); end
      else ef = 3'd4;
    end
    ld_req = 1'b1; ld_target = tgt; ld_sel = sel;
    @(negedge clk);
    if (poke) begin
      ld_sel = ~sel; ld_target = ~tgt;
      @(negedge clk);
    end
    ld_req = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (ld_done) break;
      @(negedge clk);
    end
    check({tag, " fault"}, 128'(ld_fault), 128'(ef));
    check({tag, " R7 reads"}, 128'(rd_cnt), 128'(er));
    if (er == 2 && rd_cnt == 2) begin
      check({tag, " R7 lo addr"}, 128'(rd_log[0]), 128'(ea));
      check({tag, " R7 hi addr"}, 128'(rd_log[1]), 128'(ea + 4));
    end
    check({tag, " R9 ldt cache"}, 128'({ldt_sel, ldt_base, ldt_limit, ldt_attr, ldt_valid}),
          128'(exp_c[0]));
    check({tag, " R9 tr cache"}, 128'({tr_sel, tr_base, tr_limit, tr_attr, tr_valid}),
          128'(exp_c[1]));
    @(negedge clk);
    check({tag, " R10 done pulse"}, 128'({ld_done, ld_fault}), 128'(0));
  endtask

  initial begin
    rst_n = 1'b0; tbl_wr_en = 1'b0; tbl_wr_sel = 1'b0; tbl_wr_data = '0;
    ld_req = 1'b0; ld_target = 1'b0; ld_sel = '0; mem_rd_valid = 1'b0;
    exp_c[0] = '0; exp_c[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset", 128'({gdt_base, gdt_limit, idt_base, idt_limit, ldt_valid, tr_valid,
          ld_busy, ld_done, ld_fault, mem_rd_req, ldt_base, tr_base}), 128'(0));

    // R2
    gdt_write(32'h0002_0000, 16'd127);
    check("R2 gdt write", 128'({gdt_base, gdt_limit}), 128'({32'h0002_0000, 16'd127}));
    tbl_wr_en = 1'b1; tbl_wr_sel = 1'b1; tbl_wr_data = {32'h0009_0000, 16'h1234};
    @(negedge clk);
    tbl_wr_en = 1'b0;
    check("R2 idt clamp", 128'({idt_base, idt_limit}), 128'({32'h0009_0000, 16'h07FF}));
    tbl_wr_en = 1'b1; tbl_wr_sel = 1'b1; tbl_wr_data = {32'h0009_8000, 16'h0400};
    @(negedge clk);
    tbl_wr_en = 1'b0;
    check("R2 idt write", 128'({idt_base, idt_limit, gdt_limit}),
          128'({32'h0009_8000, 16'h0400, 16'd127}));

    // R3 R4 R5 R6 R8 R9: sweep of index, table bit and target
    for (int idx = 0; idx < 20; idx++)
      for (int ti = 0; ti < 2; ti++)
        for (int t = 0; t < 2; t++) begin
          lat = idx % 3;
          do_load(t[0], {idx[12:0], ti[0], idx[1:0]}, 32'h0002_0000, 16'd127, 1'b0,
                  "R3-6,R8 sweep");
        end

    // R10: request during busy is ignored
    lat = 2;
    do_load(1'b0, {13'd5, 3'b000}, 32'h0002_0000, 16'd127, 1'b1, "R10 busy");
    do_load(1'b1, {13'd6, 3'b011}, 32'h0002_0000, 16'd127, 1'b1, "R10 busy");

    // R11: same-cycle table write and load request
    lat = 1;
    tbl_wr_en = 1'b1; tbl_wr_sel = 1'b0; tbl_wr_data = {32'h0003_0100, 16'd127};
    fork
      do_load(1'b0, {13'd10, 3'b000}, 32'h0002_0000, 16'd127, 1'b0, "R11 old base");
      begin @(negedge clk); tbl_wr_en = 1'b0; end
    join
    check("R11 new base", 128'(gdt_base), 128'(32'h0003_0100));
    do_load(1'b1, {13'd6, 3'b000}, 32'h0003_0100, 16'd127, 1'b0, "R11 after");
    tbl_wr_en = 1'b1; tbl_wr_sel = 1'b0; tbl_wr_data = {32'h0003_0100, 16'h00FF};
    fork
      do_load(1'b1, {13'd21, 3'b000}, 32'h0003_0100, 16'd127, 1'b0, "R11 old limit");
      begin @(negedge clk); tbl_wr_en = 1'b0; end
    join
    do_load(1'b1, {13'd21, 3'b000}, 32'h0003_0100, 16'h00FF, 1'b0, "R11 new limit");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule